// File: doc/BRIEF.md
# Interval Timer Host Bus Command Decoder

This block sits between an 8-bit parallel host bus and the three counting channels of an interval timer. The host drives a chip select, active-low read and write strobes, a 2-bit address and a write data byte. The block samples these asynchronous bus signals into the system clock domain. It works out whether a cycle targets one of the three counters or the shared control address. It then turns each finished write or read into a single-cycle command pulse for the channel concerned.

A write to the control address is split into its fields. The top two bits pick a channel or request a read-back. The next two bits pick the byte access format, or ask for a counter latch. The next three bits give the mode, and the lowest bit selects decimal counting. Each channel latches the shared field outputs when its program pulse fires. A write to a counter address produces a load pulse and presents the byte. A read steers the byte that the addressed channel offers onto the output bus, and the data bus output enable is raised only while the read is in progress.

Top module: `tmr_bus_decoder`

## Requirements
- R1: When `cs_n` is high, strobes on `wr_n` and `rd_n` produce no command pulse and leave `dout_oe` low.
- R2: A write to address 0, 1 or 2 produces one `load_stb` pulse on that channel bit only, and `cmd_byte` holds the written byte while the pulse is high.
- R3: A write to address 3 whose bits [7:6] equal 0, 1 or 2 and whose bits [5:4] are non-zero produces one `prog_stb` pulse for that channel. In the same cycle `cfg_rw` holds bits [5:4] and `cfg_bcd` holds bit 0. Control words may target the channels in any order.
- R4: `cfg_mode` holds bits [3:1] of the control word, except that 110 is reported as 010 and 111 as 011. It therefore never exceeds 5.
- R5: A control word with bits [5:4] = 00 produces one `latch_stb` pulse for the channel in bits [7:6], and no `prog_stb`. `cfg_rw`, `cfg_mode` and `cfg_bcd` keep their earlier values.
- R6: A control word with bits [7:6] = 11 produces one `rdbk_stb` pulse with the byte on `cmd_byte`, and no per-channel pulse.
- R7: Every accepted bus cycle produces exactly one pulse, lasting exactly one clock cycle, across all command outputs.
- R8: While `cs_n` and `rd_n` are low at address i (0 to 2), `dout_oe` is high and `dout` equals byte i of `ch_rdata` (bits 8i+7 to 8i). When that read ends, one `rd_stb` pulse is issued for channel i.
- R9: A read at address 3 drives `dout` to 0x00 and never returns a stored control word.
- R10: `dout_oe` is low whenever `cs_n` or `rd_n` is high (after the synchronizer latency).
- R11: While `rst` is high, all pulses, `dout_oe`, `cfg_rw`, `cfg_mode` and `cfg_bcd` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; the cycle is taken on its rising edge |
| addr | input | 2 | Target: 0-2 counter, 3 control |
| din | input | 8 | Write data from host |
| ch_rdata | input | 24 | Read byte offered by each channel, channel i in bits 8i+7:8i |
| dout | output | 8 | Read data toward host |
| dout_oe | output | 1 | Data bus output enable |
| prog_stb | output | 3 | Per-channel program pulse |
| latch_stb | output | 3 | Per-channel counter latch pulse |
| load_stb | output | 3 | Per-channel count byte write pulse |
| rd_stb | output | 3 | Per-channel read completion pulse |
| rdbk_stb | output | 1 | Read-back command pulse |
| cmd_byte | output | 8 | Byte of the last accepted write |
| cfg_rw | output | 2 | Access format of the last program command |
| cfg_mode | output | 3 | Normalized mode of the last program command |
| cfg_bcd | output | 1 | Decimal select of the last program command |

## Verification
The assertions assume that the host holds `cs_n` low for the whole strobe, and that it holds `addr` and `din` steady while a strobe is low. They also assume that read and write strobes never overlap and that each strobe stays low for several clock cycles. The bench drives every bus cycle from a task that keeps to these rules. It changes address and data only while both strobes are high, and it keeps each strobe low for two cycles longer than the synchronizer depth. `rst` is held high from time zero, so the reset check never sees undriven values.

// File: rtl/tmr_bus_pkg.sv
package tmr_bus_pkg;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_BOTH  = 2'b11
  } acc_e;

  localparam logic [1:0] SEL_RDBK = 2'b11;

  // Fold the don't-care top bit of the periodic modes onto 0.
  function automatic logic [2:0] norm_mode(input logic [2:0] raw);
    if (raw[1]) return {1'b0, raw[1:0]};
    return raw;
  endfunction

endpackage

// File: rtl/tmr_bus_sync.sv
module tmr_bus_sync #(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          wr_evt,
  output logic          rd_evt,
  output logic          rd_act,
  output logic [AW-1:0] evt_addr,
  output logic [DW-1:0] evt_data,
  output logic [AW-1:0] cur_addr
);
  localparam int W = 3 + AW + DW;
  localparam logic [W-1:0] IDLE = {3'b111, {(AW + DW){1'b0}}};

  logic [W-1:0] pipe [SYNC_STAGES+1];
  logic [W-1:0] last, prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k <= SYNC_STAGES; k++) pipe[k] <= IDLE;
    end else begin
      pipe[0] <= {cs_n, rd_n, wr_n, addr, din};
      for (int k = 1; k <= SYNC_STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign last = pipe[SYNC_STAGES-1];
  assign prev = pipe[SYNC_STAGES];

  assign wr_evt   = last[W-3] & ~prev[W-3] & ~prev[W-1];
  assign rd_evt   = last[W-2] & ~prev[W-2] & ~prev[W-1];
  assign rd_act   = ~last[W-1] & ~last[W-2];
  assign evt_addr = prev[AW+DW-1:DW];
  assign evt_data = prev[DW-1:0];
  assign cur_addr = last[AW+DW-1:DW];
endmodule

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_bus_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_evt,
  input  logic           rd_evt,
  input  logic [AW-1:0]  evt_addr,
  input  logic [DW-1:0]  evt_data,
  output logic [NCH-1:0] prog_stb,
  output logic [NCH-1:0] latch_stb,
  output logic [NCH-1:0] load_stb,
  output logic [NCH-1:0] rd_stb,
  output logic           rdbk_stb,
  output logic [DW-1:0]  cmd_byte,
  output logic [1:0]     cfg_rw,
  output logic [2:0]     cfg_mode,
  output logic           cfg_bcd
);
  localparam logic [AW-1:0] CTRL_ADDR = {AW{1'b1}};

  logic [1:0] sel;
  acc_e       acc;
  assign sel = evt_data[DW-1:DW-2];
  assign acc = acc_e'(evt_data[DW-3:DW-4]);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_stb  <= '0;
      latch_stb <= '0;
      load_stb  <= '0;
      rd_stb    <= '0;
      rdbk_stb  <= 1'b0;
      cmd_byte  <= '0;
      cfg_rw    <= '0;
      cfg_mode  <= '0;
      cfg_bcd   <= 1'b0;
    end else begin
      prog_stb  <= '0;
      latch_stb <= '0;
      load_stb  <= '0;
      rd_stb    <= '0;
      rdbk_stb  <= 1'b0;
      if (wr_evt) begin
        cmd_byte <= evt_data;
        if (evt_addr == CTRL_ADDR) begin
          if (sel == SEL_RDBK) begin
            rdbk_stb <= 1'b1;
          end else begin
            for (int i = 0; i < NCH; i++) begin
              if (int'(sel) == i) begin
                if (acc == ACC_LATCH) begin
                  latch_stb[i] <= 1'b1;
                end else begin
                  prog_stb[i] <= 1'b1;
                  cfg_rw      <= acc;
                  cfg_mode    <= norm_mode(evt_data[3:1]);
                  cfg_bcd     <= evt_data[0];
                end
              end
            end
          end
        end else begin
          for (int i = 0; i < NCH; i++)
            if (int'(evt_addr) == i) load_stb[i] <= 1'b1;
        end
      end
      if (rd_evt) begin
        for (int i = 0; i < NCH; i++)
          if (int'(evt_addr) == i) rd_stb[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_read_steer.sv
module tmr_read_steer #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int DW  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_act,
  input  logic [AW-1:0]    cur_addr,
  input  logic [NCH*DW-1:0] ch_rdata,
  output logic [DW-1:0]    dout,
  output logic             dout_oe
);
  logic [DW-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NCH; i++)
      if (int'(cur_addr) == i) pick = ch_rdata[i*DW +: DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout    <= pick;
      dout_oe <= rd_act;
    end
  end
endmodule

// File: rtl/tmr_bus_decoder.sv
module tmr_bus_decoder #(
  parameter int NCH         = 3,
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     din,
  input  logic [NCH*DW-1:0] ch_rdata,
  output logic [DW-1:0]     dout,
  output logic              dout_oe,
  output logic [NCH-1:0]    prog_stb,
  output logic [NCH-1:0]    latch_stb,
  output logic [NCH-1:0]    load_stb,
  output logic [NCH-1:0]    rd_stb,
  output logic              rdbk_stb,
  output logic [DW-1:0]     cmd_byte,
  output logic [1:0]        cfg_rw,
  output logic [2:0]        cfg_mode,
  output logic              cfg_bcd
);
  logic          wr_evt, rd_evt, rd_act;
  logic [AW-1:0] evt_addr, cur_addr;
  logic [DW-1:0] evt_data;

  tmr_bus_sync #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .rd_act(rd_act), .evt_addr(evt_addr), .evt_data(evt_data),
    .cur_addr(cur_addr)
  );

  tmr_cmd_decode #(.NCH(NCH), .AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .wr_evt(wr_evt), .rd_evt(rd_evt),
    .evt_addr(evt_addr), .evt_data(evt_data),
    .prog_stb(prog_stb), .latch_stb(latch_stb), .load_stb(load_stb),
    .rd_stb(rd_stb), .rdbk_stb(rdbk_stb), .cmd_byte(cmd_byte),
    .cfg_rw(cfg_rw), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  tmr_read_steer #(.NCH(NCH), .AW(AW), .DW(DW)) u_rd (
    .clk(clk), .rst(rst), .rd_act(rd_act), .cur_addr(cur_addr),
    .ch_rdata(ch_rdata), .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/tmr_bus_decoder_chk.sv
module tmr_bus_decoder_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           dout_oe,
  input logic [NCH-1:0] prog_stb,
  input logic [NCH-1:0] latch_stb,
  input logic [NCH-1:0] load_stb,
  input logic [NCH-1:0] rd_stb,
  input logic           rdbk_stb,
  input logic [1:0]     cfg_rw,
  input logic [2:0]     cfg_mode,
  input logic           cfg_bcd
);
  logic [4*NCH:0] all_pulses;
  assign all_pulses = {prog_stb, latch_stb, load_stb, rd_stb, rdbk_stb};

  // R7: never more than one command pulse at a time
  p_one_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(all_pulses));

  // R7: pulses last a single cycle
  p_pulse_width_r7: assert property (@(posedge clk) disable iff (rst)
    (|all_pulses) |=> (all_pulses == '0));

  // R4: normalized mode stays within 0..5
  p_mode_legal_r4: assert property (@(posedge clk) disable iff (rst)
    cfg_mode <= 3'd5);

  // R5: configuration fields change only with a program pulse
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (prog_stb == '0) |-> ($stable(cfg_rw) && $stable(cfg_mode) && $stable(cfg_bcd)));

  // R11: reset clears pulses and the output enable
  p_reset_clear_r11: assert property (@(posedge clk)
    rst |=> (all_pulses == '0 && !dout_oe && cfg_rw == 2'b00 && cfg_mode == 3'd0 && !cfg_bcd));
endmodule

bind tmr_bus_decoder tmr_bus_decoder_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .dout_oe(dout_oe), .prog_stb(prog_stb),
  .latch_stb(latch_stb), .load_stb(load_stb), .rd_stb(rd_stb),
  .rdbk_stb(rdbk_stb), .cfg_rw(cfg_rw), .cfg_mode(cfg_mode),
  .cfg_bcd(cfg_bcd)
);

// File: tb/tmr_bus_decoder_tb_top.sv
module tmr_bus_decoder_tb_top;
  localparam int CLK_P = 10;
  localparam int NCH   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] din = '0;
  logic [23:0] ch_rdata = 24'hC3_5A_17;
  logic [7:0] dout;
  logic dout_oe;
  logic [2:0] prog_stb, latch_stb, load_stb, rd_stb;
  logic rdbk_stb, cfg_bcd;
  logic [7:0] cmd_byte;
  logic [1:0] cfg_rw;
  logic [2:0] cfg_mode;

  always #(CLK_P/2) clk = ~clk;

  tmr_bus_decoder dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(din), .ch_rdata(ch_rdata), .dout(dout),
    .dout_oe(dout_oe), .prog_stb(prog_stb), .latch_stb(latch_stb),
    .load_stb(load_stb), .rd_stb(rd_stb), .rdbk_stb(rdbk_stb),
    .cmd_byte(cmd_byte), .cfg_rw(cfg_rw), .cfg_mode(cfg_mode),
    .cfg_bcd(cfg_bcd)
  );

  int n_chk = 0, n_bad = 0;
  int c_prog[NCH], c_latch[NCH], c_load[NCH], c_rd[NCH];
  int c_rdbk, c_total;
  logic [7:0] s_byte;
  logic [1:0] s_rw;
  logic [2:0] s_mode;
  logic s_bcd;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic mon_clear();
    for (int i = 0; i < NCH; i++) begin
      c_prog[i] = 0; c_latch[i] = 0; c_load[i] = 0; c_rd[i] = 0;
    end
    c_rdbk = 0; c_total = 0;
  endtask

  task automatic watch(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      c_total += $countones({prog_stb, latch_stb, load_stb, rd_stb, rdbk_stb});
      if (rdbk_stb) c_rdbk++;
      for (int i = 0; i < NCH; i++) begin
        if (prog_stb[i])  c_prog[i]++;
        if (latch_stb[i]) c_latch[i]++;
        if (load_stb[i])  c_load[i]++;
        if (rd_stb[i])    c_rd[i]++;
      end
      if (|{prog_stb, latch_stb, load_stb, rdbk_stb}) begin
        s_byte = cmd_byte; s_rw = cfg_rw; s_mode = cfg_mode; s_bcd = cfg_bcd;
      end
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input bit sel);
    mon_clear();
    @(negedge clk);
    addr = a; din = d; cs_n = ~sel;
    @(negedge clk); wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    watch(8);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0 && {prog_stb, latch_stb, load_stb, rd_stb, rdbk_stb} == '0,
        "R11 reset pulses/oe", {dout_oe, prog_stb, latch_stb, load_stb, rd_stb, rdbk_stb}, 0);
    chk({cfg_rw, cfg_mode, cfg_bcd} == '0, "R11 reset cfg", {cfg_rw, cfg_mode, cfg_bcd}, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_count_writes();
    logic [7:0] pat [3] = '{8'hA5, 8'h3C, 8'h00};
    for (int i = 0; i < NCH; i++) begin
      bus_write(2'(i), pat[i], 1'b1);
      chk(c_load[i] == 1 && c_total == 1, "R2 load pulse", c_load[i], 1);
      chk(s_byte == pat[i], "R2 load byte", s_byte, pat[i]);
      chk(c_total == 1, "R7 one pulse per write", c_total, 1);
    end
  endtask

  task automatic t_prog_order();
    // channels in order 2, 0, 1; fields rw / mode / bcd vary
    int chs [3] = '{2, 0, 1};
    logic [1:0] rws [3] = '{2'b11, 2'b01, 2'b10};
    logic [2:0] mds [3] = '{3'd0, 3'd5, 3'd1};
    logic bcds [3] = '{1'b1, 1'b0, 1'b1};
    for (int k = 0; k < 3; k++) begin
      bus_write(2'b11, {2'(chs[k]), rws[k], mds[k], bcds[k]}, 1'b1);
      chk(c_prog[chs[k]] == 1 && c_total == 1, "R3 prog pulse target", c_prog[chs[k]], 1);
      chk(s_rw == rws[k] && s_bcd == bcds[k], "R3 rw/bcd fields", {s_rw, s_bcd}, {rws[k], bcds[k]});
      chk(s_mode == mds[k], "R4 mode pass", s_mode, mds[k]);
    end
  endtask

  task automatic t_mode_norm();
    for (int m = 0; m < 8; m++) begin
      logic [2:0] exp_m;
      exp_m = (m == 6) ? 3'd2 : (m == 7) ? 3'd3 : 3'(m);
      bus_write(2'b11, {2'b01, 2'b11, 3'(m), 1'b0}, 1'b1);
      chk(c_prog[1] == 1 && s_mode == exp_m, "R4 mode normalize", s_mode, exp_m);
    end
  endtask

  task automatic t_latch();
    bus_write(2'b11, {2'b00, 2'b11, 3'd4, 1'b1}, 1'b1);
    bus_write(2'b11, {2'b00, 2'b00, 3'd2, 1'b0}, 1'b1);
    chk(c_latch[0] == 1 && c_total == 1, "R5 latch pulse only", c_total, 1);
    chk(cfg_rw == 2'b11 && cfg_mode == 3'd4 && cfg_bcd == 1'b1, "R5 cfg kept",
        {cfg_rw, cfg_mode, cfg_bcd}, {2'b11, 3'd4, 1'b1});
    bus_write(2'b11, {2'b10, 2'b00, 3'd0, 1'b0}, 1'b1);
    chk(c_latch[2] == 1 && c_total == 1, "R5 latch ch2", c_latch[2], 1);
  endtask

  task automatic t_readback();
    bus_write(2'b11, 8'hE2, 1'b1);
    chk(c_rdbk == 1 && c_total == 1, "R6 readback pulse only", c_total, 1);
    chk(s_byte == 8'hE2, "R6 readback byte", s_byte, 8'hE2);
  endtask

  task automatic t_cs_ignored();
    bus_write(2'b00, 8'h55, 1'b0);
    chk(c_total == 0, "R1 write without select", c_total, 0);
    bus_write(2'b11, 8'h76, 1'b0);
    chk(c_total == 0, "R1 control without select", c_total, 0);
    @(negedge clk); addr = 2'b01; rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(dout_oe == 1'b0, "R1 read without select oe", dout_oe, 0);
    mon_clear(); rd_n = 1'b1; watch(8);
    chk(c_total == 0, "R1 read without select pulse", c_total, 0);
  endtask

  task automatic do_read(input logic [1:0] a, input logic [7:0] exp_d, input string tag);
    mon_clear();
    @(negedge clk); addr = a; cs_n = 1'b0;
    @(negedge clk); rd_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(dout_oe == 1'b1, {tag, " oe"}, dout_oe, 1);
    chk(dout == exp_d, {tag, " data"}, dout, exp_d);
    rd_n = 1'b1;
    watch(8);
    chk(dout_oe == 1'b0, "R10 oe drops with rd high", dout_oe, 0);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reads();
    do_read(2'b00, 8'h17, "R8 ch0");
    chk(c_rd[0] == 1 && c_total == 1, "R8 rd pulse ch0", c_rd[0], 1);
    do_read(2'b10, 8'hC3, "R8 ch2");
    chk(c_rd[2] == 1 && c_total == 1, "R8 rd pulse ch2", c_rd[2], 1);
    ch_rdata = 24'h00_E9_00;
    do_read(2'b01, 8'hE9, "R8 ch1");
    chk(c_rd[1] == 1 && c_total == 1, "R8 rd pulse ch1", c_rd[1], 1);
    bus_write(2'b11, 8'h7F, 1'b1);
    ch_rdata = 24'hFF_FF_FF;
    do_read(2'b11, 8'h00, "R9 control read");
    chk(c_total == 0, "R9 no pulse on control read", c_total, 0);
  endtask

  task automatic t_release();
    @(negedge clk); addr = 2'b00; cs_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0, "R10 selected but no read", dout_oe, 0);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(dout_oe == 1'b0, "R10 idle", dout_oe, 0);
  endtask

  bit done = 0;
  initial begin
    t_reset();
    t_count_writes();
    t_prog_order();
    t_mode_norm();
    t_latch();
    t_readback();
    t_cs_ignored();
    t_reads();
    t_release();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule